// File: doc/BRIEF.md
# Serial ADC Output Shifter

This block is the digital output side of a low-power sampling converter that has a three-wire serial port. The port has an active-low select, a serial clock driven by the host and a data line that can be switched off. The block runs on the chip's system clock and treats the select and serial-clock pins as synchronous inputs. It finds their edges by comparing each pin with its value one clock earlier. Every output is registered, so it changes on the first system-clock edge that sees the pin edge.

A falling select wakes the block, enables the data line and drives the first of four leading zeros. It also puts the sampler in track. Each later serial-clock falling edge moves the frame on by one position. On the third falling edge the sampler goes to hold and the parallel result code is latched. The result is then shifted out MSB first, directly after the zeros. The parameter `RES_BITS` picks a 12-, 10- or 8-bit result, which gives a frame of 16, 14 or 12 clocks. On the last falling edge of the frame the line is disabled and the block powers down. If select rises before that edge, the conversion is abandoned and the block reports it as an aborted frame.

Top module: `adcSerialShifter`

## Requirements
- R1: After reset, `powerDown`=1, `sdoEn`=0, `sdo`=0, `trackMode`=0 and `aborted`=0.
- R2: On a select falling edge, the outputs take these values one system clock later: `sdoEn`=1, `sdo`=0 (the first leading zero), `powerDown`=0, `trackMode`=1 and `aborted`=0.
- R3: `trackMode` stays 1 until the third serial-clock falling edge after select fell, and drops to 0 on that edge.
- R4: After falling edge k of the frame, with k from 1 to F-1 and F = RES_BITS+4, `sdo` shows frame position k. Positions 0 to 3 are zero. Position 4+j is code bit RES_BITS-1-j, so the MSB comes first. Each position stays valid until the next falling edge.
- R5: The code is taken from `sampleCode` exactly at the third falling edge. Values on the bus before that edge, or after it, do not reach `sdo`.
- R6: On falling edge F the outputs become `sdoEn`=0, `sdo`=0 and `powerDown`=1. Further serial-clock edges change nothing until the next select falling edge.
- R7: If select rises while the block is powered up and before edge F, the outputs become `sdoEn`=0, `powerDown`=1, `trackMode`=0 and `aborted`=1.
- R8: `aborted` holds its value until the next select falling edge. A select rise after a complete frame leaves it at 0.
- R9: While `sdoEn`=0, `sdo` is 0. Serial-clock activity while the block is powered down enables nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples all pins |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low select from the host |
| sclk | input | 1 | Serial clock from the host |
| sampleCode | input | RES_BITS | Parallel conversion result |
| sdo | output | 1 | Serial data bit |
| sdoEn | output | 1 | Data line enable (0 = high impedance) |
| powerDown | output | 1 | Block is powered down |
| trackMode | output | 1 | Sampler is tracking |
| aborted | output | 1 | Last frame was cut short by select |

## Verification
Three instances are built, at 12, 10 and 8 bits, and all three see the same pin activity. A full 16-edge frame then shows whether each width stops at its own length and ignores the extra edges. Codes are walking ones, all zeros, all ones and scrambled values. The code bus holds the complement of the code until select has fallen, and again after the third edge. This separates latching on the third edge from latching at select or following the bus live. A sweep of select releases after 0 to 15 edges separates aborts from normal completion at each frame length.

// File: rtl/adcShiftPkg.sv
package adcShiftPkg;
  // One-cycle strobes from the control into the datapath
  typedef struct packed {
    logic start;  // select fell: enable line, first leading zero
    logic load;   // third falling edge: capture the code
    logic shift;  // drive the next result bit
    logic stop;   // frame done or aborted: release the line
  } frameStrobes_t;
endpackage

// File: rtl/adcShiftCtrl.sv
module adcShiftCtrl
  import adcShiftPkg::*;
#(
  parameter int RES_BITS = 12
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          csN,
  input  logic          sclk,
  output frameStrobes_t strobes,
  output logic          powerDown,
  output logic          trackMode,
  output logic          aborted
);
  localparam int FRAME = RES_BITS + 4;
  localparam int CNT_W = $clog2(FRAME + 1);
  localparam logic [CNT_W-1:0] HOLD_EDGE  = CNT_W'(3);
  localparam logic [CNT_W-1:0] FIRST_DATA = CNT_W'(4);
  localparam logic [CNT_W-1:0] LAST_EDGE  = CNT_W'(FRAME);

  logic csPrev, sclkPrev;
  logic csFall, csRise, sclkFall, active, countEdge;
  logic [CNT_W-1:0] edgeCnt, edgeNext;

  assign csFall    = csPrev & ~csN;
  assign csRise    = ~csPrev & csN;
  assign sclkFall  = sclkPrev & ~sclk;
  assign active    = ~powerDown;
  assign countEdge = active & ~csN & sclkFall;
  assign edgeNext  = edgeCnt + CNT_W'(1);

  always_comb begin
    strobes.start = csFall;
    strobes.load  = countEdge && (edgeNext == HOLD_EDGE);
    strobes.shift = countEdge && (edgeNext >= FIRST_DATA) && (edgeNext < LAST_EDGE);
    strobes.stop  = (countEdge && (edgeNext == LAST_EDGE)) || (csRise && active);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPrev    <= 1'b1;
      sclkPrev  <= 1'b1;
      edgeCnt   <= '0;
      powerDown <= 1'b1;
      trackMode <= 1'b0;
      aborted   <= 1'b0;
    end else begin
      csPrev   <= csN;
      sclkPrev <= sclk;
      if (csFall) begin
        powerDown <= 1'b0;
        trackMode <= 1'b1;
        aborted   <= 1'b0;
        edgeCnt   <= '0;
      end else if (csRise && active) begin
        powerDown <= 1'b1;
        trackMode <= 1'b0;
        aborted   <= 1'b1;
      end else if (countEdge) begin
        edgeCnt <= edgeNext;
        if (edgeNext == HOLD_EDGE) trackMode <= 1'b0;
        if (edgeNext == LAST_EDGE) powerDown <= 1'b1;
      end
    end
  end

  // R7
  abort_powerdown_chk: assert property (@(posedge clk) disable iff (!rstN)
    (csRise && active) |=> (powerDown && aborted && !trackMode));

  // R3
  track_awake_chk: assert property (@(posedge clk) disable iff (!rstN)
    trackMode |-> !powerDown);

  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.start, strobes.load, strobes.shift, strobes.stop}));

  // R6
  edge_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    edgeCnt <= LAST_EDGE);
endmodule

// File: rtl/adcShiftData.sv
module adcShiftData
  import adcShiftPkg::*;
#(
  parameter int RES_BITS = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  frameStrobes_t       strobes,
  input  logic [RES_BITS-1:0] code,
  output logic                sdo,
  output logic                sdoEn
);
  logic [RES_BITS-1:0] shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      sdo      <= 1'b0;
      sdoEn    <= 1'b0;
    end else begin
      if (strobes.start) begin
        sdoEn <= 1'b1;
        sdo   <= 1'b0;
      end
      if (strobes.load) shiftReg <= code;
      if (strobes.shift) begin
        sdo      <= shiftReg[RES_BITS-1];
        shiftReg <= {shiftReg[RES_BITS-2:0], 1'b0};
      end
      if (strobes.stop) begin
        sdoEn <= 1'b0;
        sdo   <= 1'b0;
      end
    end
  end

  // R9
  idle_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sdoEn |-> !sdo);

  // R2
  start_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.start |=> (sdoEn && !sdo));

  // R6
  stop_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.stop |=> !sdoEn);
endmodule

// File: rtl/adcSerialShifter.sv
module adcSerialShifter
  import adcShiftPkg::*;
#(
  parameter int RES_BITS = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                csN,
  input  logic                sclk,
  input  logic [RES_BITS-1:0] sampleCode,
  output logic                sdo,
  output logic                sdoEn,
  output logic                powerDown,
  output logic                trackMode,
  output logic                aborted
);
  frameStrobes_t strobes;

  adcShiftCtrl #(.RES_BITS(RES_BITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk),
    .strobes(strobes), .powerDown(powerDown),
    .trackMode(trackMode), .aborted(aborted)
  );

  adcShiftData #(.RES_BITS(RES_BITS)) u_data (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .code(sampleCode), .sdo(sdo), .sdoEn(sdoEn)
  );

  // R9
  enable_awake_chk: assert property (@(posedge clk) disable iff (!rstN)
    sdoEn |-> !powerDown);
endmodule

// File: tb/test_adcSerialShifter.sv
module test_adcSerialShifter;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1;
  logic sclk = 1'b1;
  logic [11:0] code = '0;
  logic sdo[3], sdoEn[3], powerDown[3], trackMode[3], aborted[3];
  int nChecks = 0;
  int nFail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  adcSerialShifter #(.RES_BITS(12)) i_adcSerialShifter (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sampleCode(code),
    .sdo(sdo[0]), .sdoEn(sdoEn[0]), .powerDown(powerDown[0]),
    .trackMode(trackMode[0]), .aborted(aborted[0]));
  adcSerialShifter #(.RES_BITS(10)) i_adcSerialShifter_w10 (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sampleCode(code[9:0]),
    .sdo(sdo[1]), .sdoEn(sdoEn[1]), .powerDown(powerDown[1]),
    .trackMode(trackMode[1]), .aborted(aborted[1]));
  adcSerialShifter #(.RES_BITS(8)) i_adcSerialShifter_w8 (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sampleCode(code[7:0]),
    .sdo(sdo[2]), .sdoEn(sdoEn[2]), .powerDown(powerDown[2]),
    .trackMode(trackMode[2]), .aborted(aborted[2]));

  function automatic int widthOf(int i);
    return 12 - 2 * i;
  endfunction

  function automatic logic expBit(int w, int k, logic [11:0] v);
    if (k < 4) return 1'b0;
    return v[w - 1 - (k - 4)];
  endfunction

  task automatic chk(string req, int i, string what, logic act, logic exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s W=%0d %s actual=%0b expected=%0b", req, widthOf(i), what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic runFrame(logic [11:0] v);
    code = ~v;
    csN = 1'b0;
    step();
    for (int i = 0; i < 3; i++) begin
      chk("R2", i, "sdoEn", sdoEn[i], 1'b1);
      chk("R2", i, "sdo", sdo[i], 1'b0);
      chk("R2", i, "powerDown", powerDown[i], 1'b0);
      chk("R2", i, "trackMode", trackMode[i], 1'b1);
    end
    code = v;
    for (int k = 1; k <= 16; k++) begin
      sclk = 1'b0;
      step();
      for (int i = 0; i < 3; i++) begin
        int w = widthOf(i);
        if (k < w + 4) begin
          chk("R4", i, "sdoEn", sdoEn[i], 1'b1);
          chk("R4 R5", i, $sformatf("sdo edge %0d", k), sdo[i], expBit(w, k, v));
          chk("R3", i, "trackMode", trackMode[i], (k < 3) ? 1'b1 : 1'b0);
        end else begin
          chk("R6", i, "sdoEn", sdoEn[i], 1'b0);
          chk("R6", i, "sdo", sdo[i], 1'b0);
          chk("R6", i, "powerDown", powerDown[i], 1'b1);
        end
      end
      if (k == 3) code = ~v;
      sclk = 1'b1;
      step();
    end
    csN = 1'b1;
    step();
    for (int i = 0; i < 3; i++) begin
      chk("R8", i, "aborted", aborted[i], 1'b0);
      chk("R6", i, "powerDown", powerDown[i], 1'b1);
    end
  endtask

  task automatic runAbort(int m, logic [11:0] v);
    code = v;
    csN = 1'b0;
    step();
    for (int k = 1; k <= m; k++) begin
      sclk = 1'b0;
      step();
      sclk = 1'b1;
      step();
    end
    csN = 1'b1;
    step();
    for (int i = 0; i < 3; i++) begin
      logic cut = (m < widthOf(i) + 4);
      chk("R7", i, "aborted", aborted[i], cut);
      chk("R7", i, "sdoEn", sdoEn[i], 1'b0);
      chk("R7", i, "powerDown", powerDown[i], 1'b1);
      chk("R7", i, "trackMode", trackMode[i], 1'b0);
    end
    for (int t = 0; t < 2; t++) begin
      sclk = 1'b0;
      step();
      sclk = 1'b1;
      step();
    end
    for (int i = 0; i < 3; i++) begin
      chk("R8", i, "aborted held", aborted[i], (m < widthOf(i) + 4) ? 1'b1 : 1'b0);
      chk("R9", i, "sdoEn idle", sdoEn[i], 1'b0);
      chk("R9", i, "sdo idle", sdo[i], 1'b0);
    end
    csN = 1'b0;
    step();
    for (int i = 0; i < 3; i++) chk("R8", i, "aborted cleared", aborted[i], 1'b0);
    csN = 1'b1;
    step();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    step();
    step();
    step();
    for (int i = 0; i < 3; i++) begin
      chk("R1", i, "powerDown", powerDown[i], 1'b1);
      chk("R1", i, "sdoEn", sdoEn[i], 1'b0);
      chk("R1", i, "sdo", sdo[i], 1'b0);
      chk("R1", i, "trackMode", trackMode[i], 1'b0);
      chk("R1", i, "aborted", aborted[i], 1'b0);
    end
    rstN = 1'b1;
    step();
    for (int t = 0; t < 4; t++) begin
      sclk = 1'b0;
      step();
      sclk = 1'b1;
      step();
      for (int i = 0; i < 3; i++) begin
        chk("R9", i, "sdoEn idle sclk", sdoEn[i], 1'b0);
        chk("R9", i, "powerDown idle sclk", powerDown[i], 1'b1);
      end
    end
    for (int n = 0; n < 24; n++) begin
      logic [11:0] v;
      if (n < 12) v = 12'(1 << n);
      else if (n == 12) v = 12'h000;
      else if (n == 13) v = 12'hFFF;
      else v = 12'((n * 2651) ^ (n << 5));
      runFrame(v);
    end
    for (int m = 0; m < 16; m++) runAbort(m, 12'(m * 397 + 5));
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule